// File: doc/BRIEF.md
# Register-Mapped SPI Master with Queued Transfers

This block is an SPI master that sits behind a small register bus. It has two addressable words. The configuration word holds the run enable, the clock mode, the frame length, the clock divider settings, the interrupt mode and the chip-select choice. It also carries two read-only fields: the queue depth and the busy flag. Writing the data word while the block is enabled queues a transmit word. A serial engine takes queued words one at a time and shifts each out MSB-first on MOSI while it samples MISO. Each received frame lands LSB-aligned in a receive queue, and software drains that queue by reading the data word.

The serial clock comes from a prescaler table entry multiplied by a 4-bit divider. One half period of SCK lasts (prescaler factor × divider) system cycles. Eight active-low select lines are driven straight from the configuration word. A single-cycle interrupt pulse can signal one of three events: the end of a frame, the transmit queue dropping below half full, or the transmit queue running empty. Clearing the enable bit flushes both queues and aborts the engine.

The serial engine is a three-state machine:
- IDLE: waits for a queued word.
- SHIFT: generates 2×N clock edges for an N-bit frame.
- DONE: lasts one cycle and hands the received word to the receive queue.

Its transitions are:
- IDLE→SHIFT: the block is enabled and the transmit queue is not empty. The word is popped in this cycle.
- SHIFT→DONE: the divider tick arrives on the last edge of the frame.
- DONE→IDLE: taken unconditionally.
- Any state→IDLE: the enable bit is low.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset, all of the following hold: the configuration word (address 0) reads 0x00080000, `cs_n` is 8'hFF, `sck` is 0 and `irq` is 0. The configuration word layout is:
  - bit 0: enable
  - bit 1: CPHA
  - bit 2: CPOL
  - bits 4:3: frame size
  - bits 7:5: prescaler select
  - bits 11:8: divider
  - bits 13:12: interrupt mode
  - bit 14: select enable
  - bits 17:15: select index
  - bits 21:18: read-only log2 of the queue depth (2 by default)
  - bit 31: read-only busy
  - all other bits read 0
- R2: With the select enable set, only `cs_n[index]` is low. With it clear, all eight lines are high.
- R3: A data-word write (address 1) while enabled transmits the low N bits MSB-first on MOSI, where N = 8, 16, 24 or 32 for frame size 0, 1, 2 or 3. Bits above N are ignored.
- R4: The N bits sampled from MISO are returned LSB-aligned by a data-word read, and upper bits read 0. Each read pops one word. A read from an empty receive queue returns the most recently received word.
- R5: When the engine is idle, SCK rests at the CPOL level. With CPHA=0, MISO and MOSI are valid on the first edge of each bit. With CPHA=1, they are valid on the second edge.
- R6: The SCK period is 2 × P × D system cycles. P is taken from {2,4,8,64,128,1024,2048,4096}, indexed by the prescaler select. D is the divider value, and a value of 0 acts as 1.
- R7: Busy (bit 31) reads 1 from the cycle after an accepted data write until the transmit queue is empty and the engine is idle.
- R8: A data write to a full transmit queue is discarded, so no frame is sent for it.
- R9: `irq` pulses for one cycle on one of the following events, chosen by the interrupt mode:
  - modes 0 and 1: the end of each frame
  - mode 2: the transmit count falling from at least half the depth to below half
  - mode 3: the transmit count reaching zero
- R10: Clearing the enable bit empties both queues, aborts any frame, clears busy and clears the held receive word (data reads return 0).
- R11: The depth and busy fields ignore writes. Writing all ones reads back 0x000BFFFF when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (pops the receive queue at address 1) |
| addr | input | 1 | 0 = configuration word, 1 = data word |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, combinational from addr |
| irq | output | 1 | Single-cycle interrupt pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low select lines |

## Verification
The hardest conditions to reach from the ports are the queue-level interrupt events and the full-queue discard. Both need the transmit count to reach exact values while the engine is draining it. The stimulus reaches them with back-to-back data writes on consecutive cycles. For the discard, the clock is slowed so that the queue fills faster than frames complete. The number of interrupt pulses then shows the count trajectory: a 2-word burst never reaches half-depth, a 4-word burst does, and a 6-word burst produces only five frames. Clock-mode correctness is judged by a bench monitor that samples MOSI only on the edge each CPHA/CPOL pair names as valid. MISO is looped back from MOSI, optionally inverted.

// File: rtl/spi_pkg.sv
package spi_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} shift_state_t;

    localparam int CNT_W = 17;

    localparam int B_EN    = 0;
    localparam int B_CPHA  = 1;
    localparam int B_CPOL  = 2;
    localparam int B_SIZE  = 3;
    localparam int B_PRSC  = 5;
    localparam int B_DIV   = 8;
    localparam int B_IRQM  = 12;
    localparam int B_CSEN  = 14;
    localparam int B_CSSEL = 15;
    localparam int CFG_W   = 18;

    function automatic logic [12:0] presc_factor(input logic [2:0] sel);
        unique case (sel)
            3'd0: return 13'd2;
            3'd1: return 13'd4;
            3'd2: return 13'd8;
            3'd3: return 13'd64;
            3'd4: return 13'd128;
            3'd5: return 13'd1024;
            3'd6: return 13'd2048;
            default: return 13'd4096;
        endcase
    endfunction
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int LOG2 = 2,
    parameter int W    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [LOG2:0] count
);
    localparam int DEPTH = 1 << LOG2;

    logic [W-1:0]    mem [DEPTH];
    logic [LOG2-1:0] wptr, rptr;
    logic            do_push, do_pop;

    assign full    = (count == (LOG2+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0; rptr <= '0; count <= '0;
        end else if (clr) begin
            wptr <= '0; rptr <= '0; count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            count <= count + (LOG2+1)'(do_push) - (LOG2+1)'(do_pop);
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
    import spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    input  logic [3:0] div,
    output logic       tick
);
    logic [CNT_W-1:0] cnt, half;
    logic [3:0]       eff_div;

    assign eff_div = (div == 4'd0) ? 4'd1 : div;
    assign half    = CNT_W'(presc_factor(sel)) * CNT_W'(eff_div);
    assign tick    = run && (cnt == half - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + CNT_W'(1);
    end

    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        go,
    input  logic        cpha,
    input  logic [1:0]  size,
    input  logic [31:0] tx_word,
    input  logic        miso,
    input  logic        tick,
    output logic        pop,
    output logic        active,
    output logic        done,
    output logic [31:0] rx_word,
    output logic        mosi,
    output logic        sck_lvl
);
    shift_state_t state, next;
    logic [31:0]  tx_sr, rx_sr;
    logic [5:0]   edge_cnt, last_edge;
    logic         sample, shift;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (!en) state <= ST_IDLE;
        else          state <= next;
    end

    always_comb begin
        next = state;
        pop  = 1'b0;
        unique case (state)
            ST_IDLE:  if (go) begin next = ST_SHIFT; pop = 1'b1; end
            ST_SHIFT: if (tick && edge_cnt == last_edge) next = ST_DONE;
            ST_DONE:  next = ST_IDLE;
            default:  next = ST_IDLE;
        endcase
    end

    assign active  = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign sample  = cpha ? edge_cnt[0] : ~edge_cnt[0];
    assign shift   = cpha ? (~edge_cnt[0] && edge_cnt != 6'd0) : edge_cnt[0];
    assign mosi    = tx_sr[31];
    assign rx_word = rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0; rx_sr <= '0; edge_cnt <= '0; last_edge <= '0; sck_lvl <= 1'b0;
        end else if (!en) begin
            tx_sr <= '0; rx_sr <= '0; edge_cnt <= '0; last_edge <= '0; sck_lvl <= 1'b0;
        end else if (pop) begin
            tx_sr     <= tx_word << {~size, 3'b000};
            rx_sr     <= '0;
            edge_cnt  <= '0;
            last_edge <= {size, 4'hF};
            sck_lvl   <= 1'b0;
        end else if (state == ST_SHIFT && tick) begin
            sck_lvl  <= ~sck_lvl;
            edge_cnt <= edge_cnt + 6'd1;
            if (sample) rx_sr <= {rx_sr[30:0], miso};
            if (shift)  tx_sr <= {tx_sr[30:0], 1'b0};
        end
    end

    assert_sck_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sck_lvl);
    assert_done_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
    import spi_pkg::*;
#(
    parameter int FIFO_LOG2 = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic [7:0]  cs_n
);
    localparam int DEPTH = 1 << FIFO_LOG2;
    localparam int HALF  = DEPTH / 2;

    logic [CFG_W-1:0]   cfg;
    logic               en, busy, tick, pop, active, done, sck_lvl, irq_evt;
    logic [31:0]        tx_head, rx_head, rx_word, last_rx;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic [FIFO_LOG2:0] tx_cnt, rx_cnt, tx_cnt_q;
    logic               wr_cfg, wr_dat, rd_dat;

    assign en     = cfg[B_EN];
    assign wr_cfg = wr_en && !addr;
    assign wr_dat = wr_en && addr && en;
    assign rd_dat = rd_en && addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg <= '0;
        else if (wr_cfg) cfg <= wdata[CFG_W-1:0];
    end

    spi_fifo #(.LOG2(FIFO_LOG2), .W(32)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(!en), .push(wr_dat), .pop(pop),
        .din(wdata), .dout(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_cnt));

    spi_fifo #(.LOG2(FIFO_LOG2), .W(32)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(!en), .push(done), .pop(rd_dat),
        .din(rx_word), .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt));

    spi_clkgen u_clk (
        .clk(clk), .rst_n(rst_n), .run(active),
        .sel(cfg[B_PRSC +: 3]), .div(cfg[B_DIV +: 4]), .tick(tick));

    spi_shifter u_eng (
        .clk(clk), .rst_n(rst_n), .en(en), .go(en && !tx_empty),
        .cpha(cfg[B_CPHA]), .size(cfg[B_SIZE +: 2]), .tx_word(tx_head),
        .miso(miso), .tick(tick), .pop(pop), .active(active), .done(done),
        .rx_word(rx_word), .mosi(mosi), .sck_lvl(sck_lvl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    last_rx <= '0;
        else if (!en)  last_rx <= '0;
        else if (done) last_rx <= rx_word;
    end

    assign busy = !tx_empty || active;
    assign sck  = cfg[B_CPOL] ^ sck_lvl;
    assign cs_n = cfg[B_CSEN] ? ~(8'b1 << cfg[B_CSSEL +: 3]) : 8'hFF;

    always_comb begin
        if (addr) rdata = rx_empty ? last_rx : rx_head;
        else      rdata = {busy, 9'b0, 4'(FIFO_LOG2), cfg};
    end

    always_comb begin
        unique case (cfg[B_IRQM +: 2])
            2'd2:    irq_evt = (int'(tx_cnt_q) >= HALF) && (int'(tx_cnt) < HALF);
            2'd3:    irq_evt = (tx_cnt_q != '0) && (tx_cnt == '0);
            default: irq_evt = done;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cnt_q <= '0; irq <= 1'b0;
        end else begin
            tx_cnt_q <= tx_cnt;
            irq      <= en && irq_evt;
        end
    end

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);
    assert_busy_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !tx_full) |=> busy);
    assert_flush_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: tb/spi_master_ctl_test.sv
`timescale 1ns/1ps
module spi_master_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, sck, mosi, miso;
    logic [7:0]  cs_n;
    logic        inv = 1'b0;

    int checks = 0, failures = 0;
    int irq_cnt = 0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, mon_on = 1'b0;
    logic [31:0] mon_word = '0;
    int          mon_bits = 0;

    always #2.5 clk = ~clk;

    assign miso = mosi ^ inv;

    spi_master_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n));

    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    always @(sck) begin
        if (rst_n && mon_on && (((sck !== cfg_cpol) ? 1'b1 : 1'b0) ^ cfg_cpha)) begin
            mon_word = {mon_word[30:0], mosi};
            mon_bits = mon_bits + 1;
        end
    end

    // size, cpha, cpol, invert, tx word
    localparam logic [36:0] VEC [0:5] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 32'h000000A5},
        {2'd1, 1'b1, 1'b0, 1'b1, 32'h00001234},
        {2'd2, 1'b0, 1'b1, 1'b0, 32'h00ABCDEF},
        {2'd3, 1'b1, 1'b1, 1'b0, 32'hDEADBEEF},
        {2'd3, 1'b0, 1'b0, 1'b1, 32'h80000001},
        {2'd0, 1'b1, 1'b1, 1'b1, 32'hFFFFFF3C}
    };

    function automatic logic [31:0] mk(input logic en, cpha, cpol, input logic [1:0] size,
                                       input logic [2:0] prsc, input logic [3:0] dv,
                                       input logic [1:0] irqm, input logic csen,
                                       input logic [2:0] cssel);
        return {14'b0, cssel, csen, irqm, dv, prsc, size, cpol, cpha, en};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic burst(input int n, input logic [31:0] base);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            addr = 1'b1; wdata = base + 32'(i); wr_en = 1'b1;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_idle;
        logic [31:0] v;
        v = 32'h8000_0000;
        while (v[31]) bus_rd(1'b0, v);
    endtask

    task automatic configure(input logic [31:0] c);
        cfg_cpol = c[2]; cfg_cpha = c[1];
        bus_wr(1'b0, c);
        mon_word = '0; mon_bits = 0; mon_on = 1'b1;
    endtask

    task automatic measure(output int cyc);
        realtime t1;
        @(posedge sck); t1 = $realtime;
        @(posedge sck); cyc = int'(($realtime - t1) / 5.0);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v, mask, exp;
        int n, base, per;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(1'b0, v);
        check("R1 cfg reset", v, 32'h0008_0000);
        check("R1 cs_n reset", {24'b0, cs_n}, 32'hFF);
        check("R1 sck/irq reset", {30'b0, sck, irq}, 32'h0);

        // R3 R4 R5: table of frames through a loopback, fast clock
        foreach (VEC[i]) begin
            inv = VEC[i][32];
            n = (int'(VEC[i][36:35]) + 1) * 8;
            mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
            configure(mk(1'b1, VEC[i][34], VEC[i][33], VEC[i][36:35], 3'd0, 4'd1, 2'd0, 1'b1, 3'd0));
            check("R5 sck idle level", {31'b0, sck}, {31'b0, VEC[i][33]});
            bus_wr(1'b1, VEC[i][31:0]);
            wait_idle();
            check("R3 mosi frame msb-first", mon_word & mask, VEC[i][31:0] & mask);
            check("R3 bit count", 32'(mon_bits), 32'(n));
            exp = (inv ? ~VEC[i][31:0] : VEC[i][31:0]) & mask;
            bus_rd(1'b1, v);
            check("R4 rx word", v, exp);
            check("R5 sck back at rest", {31'b0, sck}, {31'b0, VEC[i][33]});
        end
        bus_rd(1'b1, v);
        check("R4 empty read repeats last", v, exp);
        inv = 1'b0;

        // R2 chip selects
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 4'd1, 2'd0, 1'b1, 3'd3));
        check("R2 cs index 3", {24'b0, cs_n}, 32'hF7);
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 4'd1, 2'd0, 1'b1, 3'd7));
        check("R2 cs index 7", {24'b0, cs_n}, 32'h7F);
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 4'd1, 2'd0, 1'b0, 3'd7));
        check("R2 cs disabled", {24'b0, cs_n}, 32'hFF);

        // R6 clock period
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd3, 4'd2, 2'd0, 1'b0, 3'd0));
        bus_wr(1'b1, 32'h55); measure(per); wait_idle();
        check("R6 period sel3 div2", 32'(per), 32'd256);
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd3, 4'd0, 2'd0, 1'b0, 3'd0));
        bus_wr(1'b1, 32'h55); measure(per); wait_idle();
        check("R6 period div0 as 1", 32'(per), 32'd128);
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd1, 4'd3, 2'd0, 1'b0, 3'd0));
        bus_wr(1'b1, 32'h55); measure(per); wait_idle();
        check("R6 period sel1 div3", 32'(per), 32'd24);
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd5, 4'd1, 2'd0, 1'b0, 3'd0));
        bus_wr(1'b1, 32'h55); measure(per); wait_idle();
        check("R6 period sel5 div1", 32'(per), 32'd2048);

        // R7 busy right after a write
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 4'd1, 2'd0, 1'b0, 3'd0));
        bus_wr(1'b1, 32'h11);
        bus_rd(1'b0, v);
        check("R7 busy during frame", {31'b0, v[31]}, 32'h1);
        wait_idle();
        bus_rd(1'b0, v);
        check("R7 busy clear after frame", {31'b0, v[31]}, 32'h0);

        // R9 interrupt modes
        base = irq_cnt;
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 4'd1, 2'd0, 1'b0, 3'd0));
        burst(4, 32'h20); wait_idle(); repeat (4) @(negedge clk);
        check("R9 mode0 per frame", 32'(irq_cnt - base), 32'd4);
        base = irq_cnt;
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 4'd1, 2'd1, 1'b0, 3'd0));
        burst(2, 32'h30); wait_idle(); repeat (4) @(negedge clk);
        check("R9 mode1 per frame", 32'(irq_cnt - base), 32'd2);
        base = irq_cnt;
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 4'd1, 2'd2, 1'b0, 3'd0));
        burst(2, 32'h40); wait_idle(); repeat (4) @(negedge clk);
        check("R9 mode2 never half", 32'(irq_cnt - base), 32'd0);
        base = irq_cnt;
        burst(4, 32'h50); wait_idle(); repeat (4) @(negedge clk);
        check("R9 mode2 below half", 32'(irq_cnt - base), 32'd1);
        base = irq_cnt;
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 4'd1, 2'd3, 1'b0, 3'd0));
        burst(4, 32'h60); wait_idle(); repeat (4) @(negedge clk);
        check("R9 mode3 empty once", 32'(irq_cnt - base), 32'd1);

        // R8 full transmit queue drops the extra write
        base = irq_cnt;
        configure(mk(1'b1, 1'b0, 1'b0, 2'd0, 3'd3, 4'd1, 2'd0, 1'b0, 3'd0));
        burst(6, 32'h70); wait_idle(); repeat (4) @(negedge clk);
        check("R8 frames after overfill", 32'(irq_cnt - base), 32'd5);

        // R10 flush on disable
        configure(mk(1'b1, 1'b0, 1'b0, 2'd3, 3'd3, 4'd1, 2'd0, 1'b0, 3'd0));
        burst(3, 32'h80);
        repeat (100) @(negedge clk);
        bus_rd(1'b0, v);
        check("R10 busy before flush", {31'b0, v[31]}, 32'h1);
        base = irq_cnt;
        configure(32'h0);
        bus_rd(1'b0, v);
        check("R10 busy cleared", {31'b0, v[31]}, 32'h0);
        check("R10 sck at rest", {31'b0, sck}, 32'h0);
        bus_rd(1'b1, v);
        check("R10 rx cleared", v, 32'h0);
        repeat (3000) @(negedge clk);
        check("R10 no frame completes", 32'(irq_cnt - base), 32'd0);

        // R11 read-only fields
        bus_wr(1'b0, 32'hFFFF_FFFF);
        bus_rd(1'b0, v);
        check("R11 read-only fields", v, 32'h000B_FFFF);
        check("R11 R2 cs index 7 via all ones", {24'b0, cs_n}, 32'h7F);

        finish_run();
    end
endmodule